// File: doc/BRIEF.md
# Arithmetic Shift and Rotate Unit

This block shifts or rotates a data word by an amount taken from a signed count operand. The count's sign selects the direction. A positive count moves bits toward the most significant end. A negative count moves them toward the least significant end by the count's magnitude. An arithmetic shift to the right copies the sign bit into the vacated positions. A shift to the left fills with zeros and reports signed overflow whenever the sign of the word changes at any point during the shift. A rotate feeds each bit that leaves one end back in at the other end.

Alongside the result, the unit produces four condition flags: negative, zero, overflow and carry. It also takes the carry flag from the previous operation as an input. For a shift, carry is cleared. For a rotate, overflow is cleared and carry passes through unchanged. This lets a processor pipeline drop the unit into its execute stage. The result and flags are registered, so they appear one clock after the operands are presented.

Top module: `ashrot_unit`

## Requirements
- R1: Outputs are registered with a latency of one clock. A synchronous active-high reset sets the result to zero, the negative flag to 0, the zero flag to 1, and the overflow and carry flags to 0.
- R2: With the operation select at 0 (shift) and a positive count n below the data width, the result is the operand shifted toward the most significant end by n, with zeros filling the vacated low bits.
- R3: With the operation select at 0 and a negative count, the result is the operand shifted toward the least significant end by the count's magnitude, with copies of the sign bit filling the vacated high bits. A magnitude of at least the data width gives a word made entirely of the sign bit, so an all-ones operand stays all ones.
- R4: For a shift with a positive count, overflow is 1 exactly when some bit that leaves through the sign position differs from the bit that enters it. For a count of at least the data width, the result is zero and overflow equals 1 whenever the operand is nonzero.
- R5: For every shift, carry is 0. A shift with a negative count also reports overflow 0.
- R6: With the operation select at 1 (rotate), the result is the operand rotated toward the most significant end by the count modulo the data width. The count is read in two's complement, so a negative count rotates toward the least significant end by its magnitude.
- R7: For a rotate, overflow is 0 and carry equals the carry input sampled with the operands.
- R8: For both operations, the negative flag equals the result's most significant bit, and the zero flag is 1 exactly when the result is zero.
- R9: A count of zero returns the operand unchanged with overflow 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_sel | input | 1 | 0 = arithmetic shift, 1 = rotate |
| count | input | CNT_W (8) | Signed shift or rotate count |
| operand | input | W (32) | Data word to shift or rotate |
| carry_in | input | 1 | Carry flag from the previous operation |
| result | output | W (32) | Registered shifted or rotated word |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag |

## Verification
The bench builds the unit with its default 32-bit data word and 8-bit count. The count then spans -128 to +127, so magnitudes beyond the data width are reachable in both directions, including the most negative count, whose magnitude does not fit in the positive range. Random counts over the full signed range also exercise rotate amounts that wrap modulo 32. Directed vectors cover the single-bit sign-propagation examples, the all-ones right shift, left-shift overflow at one position and at very large counts, and carry pass-through on rotate.

// File: rtl/ashrot_pkg.sv
package ashrot_pkg;

  typedef enum logic {
    OP_SHIFT  = 1'b0,
    OP_ROTATE = 1'b1
  } ashrot_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } ashrot_flags_t;

endpackage

// File: rtl/ashrot_lshift.sv
// Left arithmetic barrel shifter with sign-change overflow detection.
// Each stage of 2^k positions loses sign information exactly when the
// top 2^k+1 bits of its input are not all equal.
module ashrot_lshift #(
  parameter int W   = 32,
  parameter int LOG = 5
) (
  input  logic [W-1:0]   din,
  input  logic [LOG-1:0] amt,
  input  logic           saturate,
  output logic [W-1:0]   dout,
  output logic           ovf
);

  logic [W-1:0] stg [0:LOG];
  logic [LOG:0] ov_acc;

  assign stg[0]    = din;
  assign ov_acc[0] = 1'b0;

  for (genvar k = 0; k < LOG; k++) begin : g_stage
    localparam int S = 1 << k;
    logic [S:0] win;
    logic       lost;
    assign win  = stg[k][W-1 -: S+1];
    assign lost = !((win == '0) || (&win));
    assign stg[k+1]    = amt[k] ? {stg[k][W-1-S:0], {S{1'b0}}} : stg[k];
    assign ov_acc[k+1] = ov_acc[k] | (amt[k] & lost);
  end

  assign dout = saturate ? '0 : stg[LOG];
  assign ovf  = saturate ? (|din) : ov_acc[LOG];

endmodule

// File: rtl/ashrot_rshift.sv
// Right arithmetic barrel shifter; vacated bits take the sign.
module ashrot_rshift #(
  parameter int W   = 32,
  parameter int LOG = 5
) (
  input  logic [W-1:0]   din,
  input  logic [LOG-1:0] amt,
  input  logic           saturate,
  output logic [W-1:0]   dout
);

  logic [W-1:0] stg [0:LOG];

  assign stg[0] = din;

  for (genvar k = 0; k < LOG; k++) begin : g_stage
    localparam int S = 1 << k;
    assign stg[k+1] = amt[k] ? {{S{stg[k][W-1]}}, stg[k][W-1:S]} : stg[k];
  end

  assign dout = saturate ? {W{din[W-1]}} : stg[LOG];

endmodule

// File: rtl/ashrot_rotate.sv
// Left rotate barrel; amount is already reduced modulo W.
module ashrot_rotate #(
  parameter int W   = 32,
  parameter int LOG = 5
) (
  input  logic [W-1:0]   din,
  input  logic [LOG-1:0] amt,
  output logic [W-1:0]   dout
);

  logic [W-1:0] stg [0:LOG];

  assign stg[0] = din;

  for (genvar k = 0; k < LOG; k++) begin : g_stage
    localparam int S = 1 << k;
    assign stg[k+1] = amt[k] ? {stg[k][W-1-S:0], stg[k][W-1:W-S]} : stg[k];
  end

  assign dout = stg[LOG];

endmodule

// File: rtl/ashrot_unit.sv
// Top: signed-count arithmetic shift / rotate with registered result and flags.
module ashrot_unit
  import ashrot_pkg::*;
#(
  parameter int W     = 32,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_sel,
  input  logic [CNT_W-1:0] count,
  input  logic [W-1:0]     operand,
  input  logic             carry_in,
  output logic [W-1:0]     result,
  output logic             flag_n,
  output logic             flag_z,
  output logic             flag_v,
  output logic             flag_c
);

  localparam int LOG = $clog2(W);

  logic             cnt_neg;
  logic [CNT_W-1:0] mag;
  logic             mag_big;
  logic [W-1:0]     l_out, r_out, rot_out;
  logic             l_ovf;
  logic [W-1:0]     res_d;
  ashrot_flags_t    flg_d;

  // Magnitude of the signed count; the most negative value maps to 2^(CNT_W-1).
  assign cnt_neg = count[CNT_W-1];
  assign mag     = cnt_neg ? (~count + 1'b1) : count;
  assign mag_big = |mag[CNT_W-1:LOG];

  ashrot_lshift #(.W(W), .LOG(LOG)) u_lsh (
    .din      (operand),
    .amt      (mag[LOG-1:0]),
    .saturate (mag_big),
    .dout     (l_out),
    .ovf      (l_ovf)
  );

  ashrot_rshift #(.W(W), .LOG(LOG)) u_rsh (
    .din      (operand),
    .amt      (mag[LOG-1:0]),
    .saturate (mag_big),
    .dout     (r_out)
  );

  ashrot_rotate #(.W(W), .LOG(LOG)) u_rot (
    .din  (operand),
    .amt  (count[LOG-1:0]),
    .dout (rot_out)
  );

  always_comb begin
    res_d = operand;
    flg_d = '0;
    case (ashrot_op_e'(op_sel))
      OP_SHIFT: begin
        if (cnt_neg) begin
          res_d   = r_out;
          flg_d.v = 1'b0;
        end else begin
          res_d   = l_out;
          flg_d.v = l_ovf;
        end
        flg_d.c = 1'b0;
      end
      OP_ROTATE: begin
        res_d   = rot_out;
        flg_d.v = 1'b0;
        flg_d.c = carry_in;
      end
      default: begin
        res_d = operand;
      end
    endcase
    flg_d.n = res_d[W-1];
    flg_d.z = (res_d == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      flag_n <= 1'b0;
      flag_z <= 1'b1;
      flag_v <= 1'b0;
      flag_c <= 1'b0;
    end else begin
      result <= res_d;
      flag_n <= flg_d.n;
      flag_z <= flg_d.z;
      flag_v <= flg_d.v;
      flag_c <= flg_d.c;
    end
  end

endmodule

// File: rtl/ashrot_chk.sv
module ashrot_chk #(
  parameter int W     = 32,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             op_sel,
  input logic [CNT_W-1:0] count,
  input logic [W-1:0]     operand,
  input logic             carry_in,
  input logic [W-1:0]     result,
  input logic             flag_n,
  input logic             flag_z,
  input logic             flag_v,
  input logic             flag_c
);

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (result == '0 && !flag_n && flag_z && !flag_v && !flag_c));

  a_r5_shift_no_carry: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 1'b0) |=> !flag_c);

  a_r5_right_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 1'b0 && count[CNT_W-1]) |=> !flag_v);

  a_r3_sign_kept: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 1'b0 && count[CNT_W-1]) |=> (result[W-1] == $past(operand[W-1])));

  a_r7_rotate_flags: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 1'b1) |=> (!flag_v && flag_c == $past(carry_in)));

  a_r9_zero_count: assert property (@(posedge clk) disable iff (rst)
    (count == '0) |=> (result == $past(operand) && !flag_v));

  a_r8_nz_match: assert property (@(posedge clk) disable iff (rst)
    (flag_n == result[W-1]) && (flag_z == (result == '0)));

endmodule

bind ashrot_unit ashrot_chk #(.W(W), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .op_sel   (op_sel),
  .count    (count),
  .operand  (operand),
  .carry_in (carry_in),
  .result   (result),
  .flag_n   (flag_n),
  .flag_z   (flag_z),
  .flag_v   (flag_v),
  .flag_c   (flag_c)
);

// File: tb/sim_ashrot_unit.sv
`timescale 1ns/1ps
module sim_ashrot_unit;

  localparam int W     = 32;
  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             op_sel = 1'b0;
  logic [CNT_W-1:0] count = '0;
  logic [W-1:0]     operand = '0;
  logic             carry_in = 1'b0;
  logic [W-1:0]     result;
  logic             flag_n, flag_z, flag_v, flag_c;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  ashrot_unit #(.W(W), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst(rst), .op_sel(op_sel), .count(count), .operand(operand),
    .carry_in(carry_in), .result(result), .flag_n(flag_n), .flag_z(flag_z),
    .flag_v(flag_v), .flag_c(flag_c)
  );

  // Unit-step reference: returns {overflow, result}.
  function automatic logic [W:0] ref_shift(input logic [W-1:0] a, input int cnt);
    logic [W-1:0] x;
    logic v;
    logic s;
    x = a;
    v = 1'b0;
    if (cnt >= 0) begin
      for (int i = 0; i < cnt; i++) begin
        s = x[W-1];
        x = x << 1;
        if (x[W-1] != s) v = 1'b1;
      end
    end else begin
      for (int i = 0; i < -cnt; i++) x = {x[W-1], x[W-1:1]};
    end
    return {v, x};
  endfunction

  function automatic logic [W-1:0] ref_rot(input logic [W-1:0] a, input int cnt);
    logic [W-1:0] x;
    int k;
    x = a;
    k = cnt & (W - 1);
    for (int i = 0; i < k; i++) x = {x[W-2:0], x[W-1]};
    return x;
  endfunction

  task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic run(input logic op, input int cnt, input logic [W-1:0] a, input logic cin);
    logic [W:0]   sv;
    logic [W-1:0] er;
    logic         ev, ec;
    string        rtag;
    @(negedge clk);
    op_sel   = op;
    count    = CNT_W'(cnt);
    operand  = a;
    carry_in = cin;
    @(negedge clk);
    if (op) begin
      er = ref_rot(a, cnt); ev = 1'b0; ec = cin; rtag = "R6";
    end else begin
      sv = ref_shift(a, cnt); er = sv[W-1:0]; ev = sv[W]; ec = 1'b0;
      rtag = (cnt == 0) ? "R9" : (cnt > 0 ? ((cnt >= W) ? "R4" : "R2") : "R3");
    end
    check(rtag, result, er);
    check(op ? "R7 overflow" : (cnt > 0 ? "R4 overflow" : "R5 overflow"), W'(flag_v), W'(ev));
    check(op ? "R7 carry" : "R5 carry", W'(flag_c), W'(ec));
    check("R8 negative", W'(flag_n), W'(er[W-1]));
    check("R8 zero", W'(flag_z), W'(er == '0));
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    tests++;
    $display("FAIL R1 watchdog expired: got hang expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 result", result, '0);
    check("R1 zero flag", W'(flag_z), W'(1));
    check("R1 other flags", W'({flag_n, flag_v, flag_c}), W'(0));
    rst = 1'b0;

    // Directed corner cases
    run(1'b0, -1, 32'h4000_0000, 1'b1);   // R3
    run(1'b0, -1, 32'h8000_0000, 1'b0);   // R3
    run(1'b0, -1, 32'hFFFF_FFFF, 1'b0);   // R3 all-ones stays
    run(1'b0, -128, 32'h8000_1234, 1'b0); // R3 large magnitude
    run(1'b0, -40, 32'h7000_0000, 1'b1);  // R3 large positive operand
    run(1'b1, 1, 32'h8000_0000, 1'b0);    // R6
    run(1'b1, -1, 32'h0000_0001, 1'b1);   // R6 negative count, R7 carry kept
    run(1'b1, 33, 32'h1234_5678, 1'b1);   // R6 modulo
    run(1'b0, 1, 32'h4000_0000, 1'b0);    // R4 overflow
    run(1'b0, 1, 32'hC000_0000, 1'b0);    // R4 no overflow
    run(1'b0, 4, 32'h0800_0001, 1'b1);    // R2/R4
    run(1'b0, 40, 32'h0000_0001, 1'b0);   // R4 big count nonzero
    run(1'b0, 127, 32'h0000_0000, 1'b0);  // R4 big count zero
    run(1'b0, 0, 32'h8765_4321, 1'b1);    // R9
    run(1'b1, 0, 32'h8765_4321, 1'b0);    // R9 via rotate

    // Constrained random mix
    for (int i = 0; i < 400; i++) begin
      logic [W-1:0] a;
      int           c;
      a = $urandom();
      if (i % 5 == 0) a = {W{a[0]}} ^ (W'(1) << (a[9:5]));
      c = int'($signed(8'($urandom())));
      if (i % 3 == 0) c = c % 34;
      run(1'(($urandom() >> 3) & 1), c, a, 1'($urandom() & 1));
    end

    // R1: reset mid-run clears outputs
    @(negedge clk);
    operand = 32'hFFFF_FFFF; count = '0; op_sel = 1'b0; rst = 1'b1;
    @(negedge clk);
    check("R1 result after reset", result, '0);
    check("R1 zero flag after reset", W'(flag_z), W'(1));
    rst = 1'b0;

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule